// File: doc/BRIEF.md
# Byte-Loaded Bit-Serial Column Shifter

This block holds one 24-dot print column and hands it back to software one dot at a time. It sits on an 8-bit processor bus and answers at one slot of a 3-bit address decode. Software fills the register with three writes to that slot. The first write lands in the top byte, the second in the middle byte and the third in the bottom byte.

After loading, each read of the same slot returns the current top bit of the register on data bit 7. When the read ends, the register moves one place toward the top and a zero enters at the bottom, so the next read presents the next dot. An internal write-phase counter tracks which byte the next write targets. A completed read returns that counter to the first byte, so software can abandon a partial load and start again.

Top module: `colshift_top`

## Requirements
- R1: After synchronous active-low reset, the register holds zero and the next write at the slot targets bits 23..16; a read at the slot returns 8'h00.
- R2: Three successive writes at address 4 place the first byte in bits 23..16, the second in bits 15..8 and the third in bits 7..0.
- R3: While a read is asserted at address 4, rdata equals {bit 23 of the register, 7'b0}: the bit is on data bit 7 and data bits 6..0 are zero.
- R4: When a read at address 4 ends (rd_en falls), the register shifts left by exactly one place with a zero into bit 0, however many cycles the read lasted.
- R5: The write phase wraps after the third write, so a fourth write at address 4 again lands in bits 23..16.
- R6: A completed read at address 4 returns the write phase to the first byte, so a load left incomplete restarts at bits 23..16.
- R7: After 24 reads following a load, the register is all zeros and any further read returns 8'h00 until the next load.
- R8: Reads and writes at any address other than 4 leave the register and the write phase unchanged, and rdata is 8'h00 whenever no read at address 4 is asserted.
- R9: If a write at address 4 happens in the same cycle as a read completion, the write is applied, the shift of that read is skipped and the phase advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Bus address of the current access |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read strobe, held for the length of the read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, three byte lanes and slot 4 in a 3-bit address space. With these values a short run reaches every write phase, the wrap after the third write, a full 24-bit drain and the reads after it. Random loads, partial loads, reads of one to three cycles and accesses at other addresses are mixed with directed cases for the wrap, the restart, a long read and a write that lands in the same cycle as a read completion.

// File: rtl/colshift_pkg.sv
// Package: shared helpers for the column shifter.
// Assumes: phase values count from 0 up to lanes-1.
package colshift_pkg;

    // Advance a write phase, wrapping after the last lane.
    function automatic int unsigned phase_next(input int unsigned ph, input int unsigned lanes);
        return (ph + 1 >= lanes) ? 0 : ph + 1;
    endfunction

endpackage

// File: rtl/colshift_decode.sv
// Module: bus access decode for the column shifter.
// Produces a write hit, a read hit and a one-cycle pulse when a read of
// the slot ends. Assumes wr_en is a one-cycle strobe and rd_en is held
// for the whole read.
module colshift_decode #(
    parameter int ADDR_W = 3,
    parameter int SLOT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic              rd_done
);
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT);

    logic rd_q;

    // Address match for the current access.
    always_comb begin
        wr_hit = wr_en && (addr == SLOT_A);
        rd_hit = rd_en && (addr == SLOT_A);
    end

    // Remember whether a slot read was in progress last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_hit;
    end

    // Trailing edge of a slot read.
    assign rd_done = rd_q && !rd_hit;
endmodule

// File: rtl/colshift_seq.sv
// Module: write-phase sequencer.
// Steps through the byte lanes from the top one down, one per write hit,
// and wraps after the last. A completed read with no write returns it to
// the first lane. Emits one write enable per lane.
module colshift_seq #(
    parameter int NUM_BYTES = 3,
    parameter int PH_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hit,
    input  logic                 rd_done,
    output logic [PH_W-1:0]      phase,
    output logic [NUM_BYTES-1:0] lane_we
);
    import colshift_pkg::*;

    // Phase counter: write advances, read completion restarts.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (wr_hit)  phase <= PH_W'(phase_next(int'(phase), NUM_BYTES));
        else if (rd_done) phase <= '0;
    end

    // Lane enable: phase 0 selects the top lane.
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_we
        assign lane_we[g] = wr_hit && (phase == PH_W'(NUM_BYTES - 1 - g));
    end
endmodule

// File: rtl/colshift_core.sv
// Module: byte-lane shift register.
// Each lane is written by its enable; with no write, a shift request moves
// the whole register one place toward the top with zero entering bit 0.
// A write in the same cycle as a shift request wins.
module colshift_core #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int REG_W    = BYTE_W * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] lane_we,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic                 shift_en,
    output logic [REG_W-1:0]     sreg
);
    logic [BYTE_W-1:0] lane_q [NUM_BYTES];
    logic [REG_W-1:0]  shifted;
    logic              any_we;

    // Shifted image and write presence.
    always_comb begin
        shifted = {sreg[REG_W-2:0], 1'b0};
        any_we  = |lane_we;
    end

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        // Lane storage: write, else shift, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)           lane_q[g] <= '0;
            else if (any_we) begin
                if (lane_we[g])   lane_q[g] <= wdata;
            end
            else if (shift_en)    lane_q[g] <= shifted[g*BYTE_W +: BYTE_W];
        end
        assign sreg[g*BYTE_W +: BYTE_W] = lane_q[g];
    end
endmodule

// File: rtl/colshift_top.sv
// Module: byte-loaded bit-serial column shifter, top level.
// Loaded a byte at a time through repeated writes at one slot; each read
// at that slot presents the top bit on the top data bit and shifts when
// the read ends. Assumes a synchronous bus in the clk domain.
module colshift_top #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 3,
    parameter int SLOT      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int REG_W = BYTE_W * NUM_BYTES;
    localparam int PH_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    logic                 wr_hit;
    logic                 rd_hit;
    logic                 rd_done;
    logic [PH_W-1:0]      phase;
    logic [NUM_BYTES-1:0] lane_we;
    logic [REG_W-1:0]     sreg;

    colshift_decode #(.ADDR_W(ADDR_W), .SLOT(SLOT)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_hit(wr_hit), .rd_hit(rd_hit), .rd_done(rd_done)
    );

    colshift_seq #(.NUM_BYTES(NUM_BYTES), .PH_W(PH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .rd_done(rd_done),
        .phase(phase), .lane_we(lane_we)
    );

    colshift_core #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_core (
        .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .wdata(wdata),
        .shift_en(rd_done), .sreg(sreg)
    );

    // Read data: top bit on the top data line during a slot read.
    always_comb begin
        rdata = '0;
        if (rd_hit) rdata[BYTE_W-1] = sreg[REG_W-1];
    end
endmodule

// File: rtl/colshift_chk.sv
// Module: property checker for the column shifter, bound to the top.
// Observes bus ports and the internal shift, phase and decode signals.
module colshift_chk #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 3,
    parameter int SLOT      = 4,
    parameter int REG_W     = 24,
    parameter int PH_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rdata,
    input logic              wr_hit,
    input logic              rd_done,
    input logic [PH_W-1:0]   phase,
    input logic [REG_W-1:0]  sreg
);
    AST_READ_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(SLOT)) |-> rdata == {sreg[REG_W-1], {(BYTE_W-1){1'b0}}}); // R3
    AST_SHIFT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !wr_hit) |=> sreg == {$past(sreg[REG_W-2:0]), 1'b0}); // R4
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < NUM_BYTES); // R5
    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !wr_hit) |=> phase == '0); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_done && !wr_hit) |=> ($stable(sreg) && $stable(phase))); // R8
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == ADDR_W'(SLOT)) |-> rdata == '0); // R8
endmodule

bind colshift_top colshift_chk #(
    .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .SLOT(SLOT),
    .REG_W(REG_W), .PH_W(PH_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rdata(rdata),
    .wr_hit(wr_hit), .rd_done(rd_done), .phase(phase), .sreg(sreg)
);

// File: tb/colshift_top_tb_top.sv
// Bench: directed and seeded random tests of the column shifter against
// a behavioural model held in bench variables.
module colshift_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] m_reg = '0;
    int          m_ph = 0;

    colshift_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    // Expected read byte from the model.
    function automatic logic [7:0] exp_read(input logic [23:0] r);
        return {r[23], 7'b0};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3'd4) begin
            m_reg[(2 - m_ph) * 8 +: 8] = d;
            m_ph = (m_ph + 1) % 3;
        end
    endtask

    task automatic bus_read(input logic [2:0] a, input int len, output logic [7:0] got);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 got = rdata;
        repeat (len) @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    // Slot read checked against the model, which then shifts.
    task automatic read_chk(input string tag, input int len);
        logic [7:0] got;
        logic [7:0] exp;
        bus_read(3'd4, len, got);
        exp = exp_read(m_reg);
        check(got == exp, tag, got, exp);
        m_reg = {m_reg[22:0], 1'b0};
        m_ph = 0;
    endtask

    task automatic load3(input logic [23:0] v);
        bus_write(3'd4, v[23:16]);
        bus_write(3'd4, v[15:8]);
        bus_write(3'd4, v[7:0]);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 24; i++) read_chk(tag, 1);
    endtask

    initial begin
        logic [7:0] got;
        void'($urandom(32'h0C01_5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then first write targets the top byte.
        bus_read(3'd4, 1, got);
        check(got == 8'h00, "R1 reset read", got, 8'h00);
        m_reg = '0; m_ph = 0;
        bus_write(3'd4, 8'h81);
        read_chk("R1 first write lands in top byte", 1);
        drain("R1 drain");

        // R2/R3: full load, every bit returned top first.
        load3(24'hA5C33C);
        drain("R2 R3 load order");

        // R4: a three-cycle read shifts once.
        load3(24'hA00000);
        read_chk("R4 long read", 3);
        read_chk("R4 one shift only", 1);
        read_chk("R4 next bit", 1);

        // R5: fourth write wraps to the top byte.
        bus_write(3'd4, 8'h11); bus_write(3'd4, 8'h22);
        bus_write(3'd4, 8'h33); bus_write(3'd4, 8'h44);
        check(m_reg == 24'h442233, "R5 model", m_reg, 24'h442233);
        drain("R5 wrap");

        // R6: partial load then read restarts the phase.
        bus_write(3'd4, 8'hFF);
        read_chk("R6 read after partial", 1);
        load3(24'h123456);
        drain("R6 restart");

        // R7: drained register reads zero.
        for (int i = 0; i < 5; i++) begin
            bus_read(3'd4, 1, got);
            check(got == 8'h00, "R7 after drain", got, 8'h00);
        end

        // R8: other addresses ignored; rdata idle zero.
        load3(24'h5A5A5A);
        bus_write(3'd3, 8'hFF);
        bus_write(3'd0, 8'h00);
        bus_read(3'd2, 2, got);
        check(got == 8'h00, "R8 other read", got, 8'h00);
        #1 check(rdata == 8'h00, "R8 idle rdata", rdata, 8'h00);
        drain("R8 untouched");

        // R9: write in the read-completion cycle wins.
        load3(24'hF0F0F0);
        @(negedge clk);
        addr = 3'd4; rd_en = 1'b1;
        #1 got = rdata;
        check(got == 8'h80, "R9 read bit", got, 8'h80);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; wdata = 8'h0F;
        @(negedge clk);
        wr_en = 1'b0;
        m_reg = 24'h0FF0F0; m_ph = 1;
        bus_write(3'd4, 8'h11);
        bus_write(3'd4, 8'h22);
        check(m_reg == 24'h0F1122, "R9 model", m_reg, 24'h0F1122);
        drain("R9 write wins");

        // Random mix against the model (R2 R3 R4 R5 R6 R8).
        for (int t = 0; t < 60; t++) begin
            int nw;
            int nr;
            nw = int'($urandom_range(0, 4));
            for (int k = 0; k < nw; k++) bus_write(3'd4, 8'($urandom));
            if ($urandom_range(0, 3) == 0) bus_write(3'($urandom_range(0, 3)), 8'($urandom));
            nr = int'($urandom_range(1, 28));
            for (int k = 0; k < nr; k++) read_chk("R4 R6 random", int'($urandom_range(1, 3)));
            if ($urandom_range(0, 3) == 0) begin
                bus_read(3'($urandom_range(5, 7)), 1, got);
                check(got == 8'h00, "R8 random other read", got, 8'h00);
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule